// File: doc/BRIEF.md
# Bit-Transform Homogenizer

This block flattens the distribution of samples from a chaotic source by rearranging the bits of a 52-bit fraction word. The word is cut into an upper and a lower 26-bit half, and the bit order inside each half is mirrored. The result is then normalized: the leading zeros and the leading one are shifted out at the top, and the space freed at the bottom is filled with zeros ending in a single one at bit 0. Because the leading one is thrown away, different inputs can land on the same output, so the map is many-to-one.

A sample goes in with a one-cycle valid strobe. The caller can give it either as a raw 52-bit fraction or as an unsigned Q1.31 value. A Q1.31 value has its 31 fraction bits placed at the top of the field and zeros below them. Two cycles later the block returns the transformed fraction together with its top 32 bits. Those 32 bits form an unsigned value in [0,1) that can drive a parameter input downstream. The stages accept a new sample on every cycle, and results come out in input order.

Top module: `bit_homogenizer`

## Requirements
- R1: While reset is held, and until the first result appears, `valid_o` is 0 and `frac_o` and `param_o` are all zeros.
- R2: For each cycle with `valid_i` high, `valid_o` is high for exactly one cycle, two clock edges later. Results appear in input order, including back-to-back samples.
- R3: Mirroring: bit 26+j of the intermediate word takes input bit 51-j, and bit j takes input bit 25-j, for j in 0..25. Each half is mirrored on its own.
- R4: Normalization: if p is the index of the highest set bit of the intermediate word, then k = 52-p. The output is the intermediate word shifted left by k and truncated to 52 bits, with bit 0 forced to 1.
- R5: An all-zero intermediate word skips normalization and gives an all-zero output.
- R6: With `fmt_i` = 1 (Q1.31), `data_i[30:0]` is placed in fraction bits 51..21 and bits 20..0 are zero. `data_i[51:31]` has no effect on the result. With `fmt_i` = 0, all 52 bits of `data_i` are used as the fraction.
- R7: `param_o` always equals `frac_o[51:20]`.
- R8: The map is many-to-one. For example, raw inputs with only bit 26 set and with only bit 27 set both give an output of 1.
- R9: While `valid_o` is low, `frac_o` and `param_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| fmt_i | input | 1 | Input format: 0 raw fraction, 1 Q1.31 |
| data_i | input | 52 | Input sample |
| valid_o | output | 1 | Result strobe |
| frac_o | output | 52 | Transformed fraction |
| param_o | output | 32 | Top 32 bits of the transformed fraction |

## Verification
The checker follows the valid strobe and an all-zero-sample flag through its own two-stage shadow. It therefore assumes that `fmt_i` and `data_i` are sampled only on edges where `valid_i` is high, and that reset is released before any sample is sent. The stimulus sends samples only after reset and changes the inputs only away from the clock edge. It mixes back-to-back and gapped samples, raw and Q1.31 formats, the all-zero case, and words with garbage above the Q1.31 field. The scoreboard compares every result, in order, against a model built from R3 to R6.

// File: rtl/hg_pkg.sv
package hg_pkg;

    typedef enum logic {
        FMT_FRAC = 1'b0,
        FMT_Q131 = 1'b1
    } hg_fmt_e;

    localparam int unsigned HG_FRAC_W  = 52;
    localparam int unsigned HG_Q_W     = 32;
    localparam int unsigned HG_PARAM_W = 32;

endpackage

// File: rtl/hg_align.sv
module hg_align #(
    parameter int unsigned FRAC_W = 52,
    parameter int unsigned Q_W    = 32
) (
    input  logic              fmt_i,
    input  logic [FRAC_W-1:0] data_i,
    output logic [FRAC_W-1:0] frac_o
);
    import hg_pkg::*;

    localparam int unsigned QF_W  = Q_W - 1;
    localparam int unsigned PAD_W = FRAC_W - QF_W;

    always_comb begin
        if (hg_fmt_e'(fmt_i) == FMT_Q131) begin
            frac_o = {data_i[QF_W-1:0], {PAD_W{1'b0}}};
        end else begin
            frac_o = data_i;
        end
    end
endmodule

// File: rtl/hg_reverse.sv
module hg_reverse #(
    parameter int unsigned FRAC_W = 52
) (
    input  logic [FRAC_W-1:0] x_i,
    output logic [FRAC_W-1:0] y_o
);
    localparam int unsigned HALF_W = FRAC_W / 2;

    for (genvar j = 0; j < HALF_W; j++) begin : g_half
        assign y_o[HALF_W + j] = x_i[FRAC_W - 1 - j];
        assign y_o[j]          = x_i[HALF_W - 1 - j];
    end
endmodule

// File: rtl/hg_norm_shift.sv
module hg_norm_shift #(
    parameter int unsigned FRAC_W = 52
) (
    input  logic [FRAC_W-1:0] x_i,
    output logic [FRAC_W-1:0] y_o
);
    localparam int unsigned CNT_W = $clog2(FRAC_W + 1);

    logic [CNT_W-1:0] lead_pos;
    logic [CNT_W-1:0] amt;
    logic             any_one;

    always_comb begin
        lead_pos = '0;
        for (int i = 0; i < FRAC_W; i++) begin
            if (x_i[i]) begin
                lead_pos = CNT_W'(i);
            end
        end
        any_one = |x_i;
        amt     = CNT_W'(FRAC_W) - lead_pos;
        if (any_one) begin
            y_o = (x_i << amt) | {{(FRAC_W-1){1'b0}}, 1'b1};
        end else begin
            y_o = '0;
        end
    end
endmodule

// File: rtl/bit_homogenizer.sv
module bit_homogenizer #(
    parameter int unsigned FRAC_W  = hg_pkg::HG_FRAC_W,
    parameter int unsigned Q_W     = hg_pkg::HG_Q_W,
    parameter int unsigned PARAM_W = hg_pkg::HG_PARAM_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               valid_i,
    input  logic               fmt_i,
    input  logic [FRAC_W-1:0]  data_i,
    output logic               valid_o,
    output logic [FRAC_W-1:0]  frac_o,
    output logic [PARAM_W-1:0] param_o
);
    typedef struct packed {
        logic              v1;
        logic [FRAC_W-1:0] mir;
        logic              v2;
        logic [FRAC_W-1:0] res;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [FRAC_W-1:0] aligned_w;
    logic [FRAC_W-1:0] mirrored_w;
    logic [FRAC_W-1:0] normed_w;

    hg_align #(.FRAC_W(FRAC_W), .Q_W(Q_W)) i_align (
        .fmt_i  (fmt_i),
        .data_i (data_i),
        .frac_o (aligned_w)
    );

    hg_reverse #(.FRAC_W(FRAC_W)) i_reverse (
        .x_i (aligned_w),
        .y_o (mirrored_w)
    );

    hg_norm_shift #(.FRAC_W(FRAC_W)) i_norm (
        .x_i (pipe_q.mir),
        .y_o (normed_w)
    );

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d.v1 = valid_i;
        if (valid_i) begin
            pipe_d.mir = mirrored_w;
        end
        pipe_d.v2 = pipe_q.v1;
        if (pipe_q.v1) begin
            pipe_d.res = normed_w;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign valid_o = pipe_q.v2;
    assign frac_o  = pipe_q.res;
    assign param_o = pipe_q.res[FRAC_W-1 -: PARAM_W];
endmodule

// File: rtl/hg_checker.sv
module hg_checker #(
    parameter int unsigned FRAC_W  = 52,
    parameter int unsigned Q_W     = 32,
    parameter int unsigned PARAM_W = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               valid_i,
    input logic               fmt_i,
    input logic [FRAC_W-1:0]  data_i,
    input logic               valid_o,
    input logic [FRAC_W-1:0]  frac_o,
    input logic [PARAM_W-1:0] param_o
);
    logic sv1, sv2, sz1, sz2, zero_in;

    assign zero_in = fmt_i ? (data_i[Q_W-2:0] == '0) : (data_i == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sv1 <= 1'b0;
            sv2 <= 1'b0;
            sz1 <= 1'b0;
            sz2 <= 1'b0;
        end else begin
            sv1 <= valid_i;
            sv2 <= sv1;
            if (valid_i) sz1 <= zero_in;
            if (sv1)     sz2 <= sz1;
        end
    end

    a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o == sv2);

    a_r4_lsb_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !sz2) |-> frac_o[0]);

    a_r5_zero_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && sz2) |-> (frac_o == '0));

    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> ($stable(frac_o) && $stable(param_o)));
endmodule

bind bit_homogenizer hg_checker #(
    .FRAC_W  (FRAC_W),
    .Q_W     (Q_W),
    .PARAM_W (PARAM_W)
) i_hg_checker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .fmt_i   (fmt_i),
    .data_i  (data_i),
    .valid_o (valid_o),
    .frac_o  (frac_o),
    .param_o (param_o)
);

// File: tb/test_bit_homogenizer.sv
module test_bit_homogenizer;
    localparam int FW = 52;
    localparam int PW = 32;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          valid_i = 1'b0;
    logic          fmt_i = 1'b0;
    logic [FW-1:0] data_i = '0;
    logic          valid_o;
    logic [FW-1:0] frac_o;
    logic [PW-1:0] param_o;

    int checks = 0;
    int errors = 0;
    int cycle  = 0;
    bit done   = 1'b0;

    logic [FW-1:0] exp_q[$];
    int            cyc_q[$];
    string         tag_q[$];
    logic [FW-1:0] last_out = '0;
    bit            run = 1'b0;

    bit_homogenizer i_bit_homogenizer (
        .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .fmt_i(fmt_i),
        .data_i(data_i), .valid_o(valid_o), .frac_o(frac_o), .param_o(param_o)
    );

    always #4 clk_i = ~clk_i;
    always @(posedge clk_i) cycle <= cycle + 1;

    function automatic logic [FW-1:0] model(logic [FW-1:0] d, logic f);
        logic [FW-1:0] fr, r;
        int p;
        fr = f ? {d[30:0], 21'b0} : d;          // R6
        for (int j = 0; j < 26; j++) begin      // R3
            r[26 + j] = fr[51 - j];
            r[j]      = fr[25 - j];
        end
        if (r == '0) return '0;                 // R5
        p = 51;
        while (!r[p]) p--;
        return (r << (52 - p)) | 52'd1;         // R4
    endfunction

    task automatic check(string req, logic [FW-1:0] act, logic [FW-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic send(logic [FW-1:0] d, logic f, string tag);
        @(negedge clk_i);
        valid_i = 1'b1;
        data_i  = d;
        fmt_i   = f;
        exp_q.push_back(model(d, f));
        cyc_q.push_back(cycle);
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            valid_i = 1'b0;
            data_i  = {$urandom, $urandom};
            fmt_i   = 1'($urandom);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk_i) begin
        if (run) begin
            if (valid_o) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected result", {51'b0, valid_o}, '0);
                end else begin
                    logic [FW-1:0] e;
                    int c;
                    string t;
                    e = exp_q.pop_front();
                    c = cyc_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, frac_o, e);
                    check("R7 param slice", {20'b0, param_o}, {20'b0, e[51:20]});
                    check("R2 latency", FW'(cycle - c), FW'(2));
                end
                last_out = frac_o;
            end else begin
                check("R9 hold frac", frac_o, last_out);
                check("R9 hold param", {20'b0, param_o}, {20'b0, last_out[51:20]});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        check("R1 valid in reset", {51'b0, valid_o}, '0);
        check("R1 frac in reset", frac_o, '0);
        check("R1 param in reset", {20'b0, param_o}, '0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        run = 1'b1;
        idle(2);

        send('0, 1'b0, "R5 zero raw");
        send({20'hFFFFF, 32'h8000_0000}, 1'b1, "R5 zero Q131 with garbage R6");
        send(52'd1 << 26, 1'b0, "R8 bit26 -> 1");
        send(52'd1 << 27, 1'b0, "R8 bit27 -> 1");
        send(52'd1 << 25, 1'b0, "R3 low half mirror");
        send(52'd1 << 51, 1'b0, "R3 upper half mirror R4");
        send(52'd1, 1'b0, "R4 leading one at 25");
        send({52{1'b1}}, 1'b0, "R4 all ones");
        send({21'h1ABCDE, 31'h1234_5678}, 1'b1, "R6 Q131 mapping");
        send({21'h000000, 31'h1234_5678}, 1'b1, "R6 Q131 upper ignored");
        idle(3);
        send(52'h0_0000_0400_0000, 1'b0, "R2 gap");
        idle(1);
        send(52'hA_5A5A_5A5A_5A5A, 1'b0, "R2 after gap");

        for (int n = 0; n < 400; n++) begin
            logic [FW-1:0] d;
            d = {$urandom, $urandom};
            if (n % 5 == 0) d = d >> ($urandom % 52);
            send(d, 1'($urandom), "R3 R4 R6 random");
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        idle(6);
        check("R2 all results drained", FW'(exp_q.size()), '0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule